// File: doc/BRIEF.md
# Runahead Mode Controller

This controller sequences the speculative "run ahead" mode of a processor core. When a retiring load misses in the second-level cache, the controller asks the core to save a checkpoint of its architectural state, records the program counter of that load, and marks the core as running ahead. While in that mode it counts any further second-level misses that the speculative stream uncovers. Exceptions raised by speculative instructions are discarded. External interrupts are held until normal execution resumes.

Leaving the mode is adaptive. A warning input says the triggering miss will return in a fixed number of cycles (`LEAD`, 20 by default). If few new misses were found (count below a programmable threshold), the controller leaves as soon as the warning arrives, which hides the exit penalty behind the remaining miss latency. If many were found, it stays `LEAD` cycles past the return of the data to look for more misses. The exit is a fixed three-pulse sequence: pipeline flush, checkpoint restore, then a fetch redirect to the recorded load. Checkpoint storage, pipeline and caches are outside the block.

States: `RA_NORMAL` (ordinary execution), `RA_RUNAHEAD` (speculating, counting misses), `RA_EXITING` (issuing flush, restore and redirect). Transitions: NORMAL to RUNAHEAD on a retiring miss; RUNAHEAD to EXITING on an early exit (warning or return with count below threshold) or on expiry of the linger window; EXITING to NORMAL after the redirect pulse.

Top module: `ra_mode_ctrl`

## Requirements
- R1: In normal mode, `l2_miss_valid` high raises `ckpt_save` in the same cycle, captures `l2_miss_pc`, and `runahead_active` is high from the next cycle.
- R2: A miss while `runahead_active` is high raises no `ckpt_save` and leaves `redirect_pc` unchanged; it increments a miss count that saturates at 2^CW-1 (15 by default) rather than wrapping.
- R3: Exit takes three consecutive cycles with exactly one of `flush`, `restore`, `redirect` high, in that order; `redirect_pc` equals the captured PC during `redirect`; `runahead_active` is low in the cycle after `redirect`.
- R4: In runahead, `fill_warn` with miss count below `miss_thresh` makes `flush` high in the next cycle.
- R5: In runahead, with miss count at or above `miss_thresh`, `fill_warn` does not start an exit; after the edge that samples `fill_done`, `flush` stays low for `LEAD` further cycles and rises on the `LEAD`-th edge after that one.
- R6: In runahead, `fill_done` with count below threshold makes `flush` high in the next cycle.
- R7: `exc_take` follows `exc_req` in the same cycle in normal mode and is low while `runahead_active` is high.
- R8: `irq_take` follows `irq_req` in the same cycle in normal mode; an `irq_req` pulse seen while `runahead_active` is high is held and raises `irq_take` for one cycle, the cycle after `redirect`.
- R9: The miss count is cleared on every entry, so counts do not carry between runahead episodes.
- R10: `fill_warn` and `fill_done` have no effect in normal mode.
- R11: During and right after reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l2_miss_valid | input | 1 | A load misses in the L2 cache (retiring in normal mode, speculative in runahead) |
| l2_miss_pc | input | PCW | PC of the missing load |
| fill_warn | input | 1 | Triggering miss returns in LEAD cycles |
| fill_done | input | 1 | Triggering miss fully serviced |
| miss_thresh | input | CW | Miss count threshold for the exit policy |
| exc_req | input | 1 | Exception raised by an instruction |
| irq_req | input | 1 | External interrupt request pulse |
| ckpt_save | output | 1 | Take checkpoint of architectural state |
| runahead_active | output | 1 | Core is in runahead or exiting |
| flush | output | 1 | Flush pipeline pulse |
| restore | output | 1 | Restore checkpoint pulse |
| redirect | output | 1 | Redirect fetch pulse |
| redirect_pc | output | PCW | PC of the runahead-causing load |
| exc_take | output | 1 | Exception passed to the core |
| irq_take | output | 1 | Interrupt presented to the core |

## Verification
The assertions watch, every cycle, the ordering and exclusivity of the flush/restore/redirect pulses, that no checkpoint is taken while already running ahead, that the recorded PC stays stable through an episode, and that exceptions and interrupts never reach the core outside normal mode. Only the bench scenarios can show the exit policy itself: early exit on a warning with few misses, the exact length of the linger window with many misses, saturation of the miss count, its clearing on re-entry, and the deferred interrupt arriving one cycle after the redirect.

// File: rtl/ra_pkg.sv
package ra_pkg;
    typedef enum logic [1:0] {
        RA_NORMAL    = 2'd0,
        RA_RUNAHEAD  = 2'd1,
        RA_EXITING   = 2'd2
    } ra_state_e;

    typedef enum logic [1:0] {
        STEP_FLUSH    = 2'd0,
        STEP_RESTORE  = 2'd1,
        STEP_REDIRECT = 2'd2
    } exit_step_e;
endpackage

// File: rtl/ra_miss_tally.sv
module ra_miss_tally #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && count != MAXV)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/ra_linger_timer.sv
module ra_linger_timer #(
    parameter int LEAD = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic load,
    output logic armed,
    output logic expired
);
    localparam int TW = $clog2(LEAD + 1);
    localparam logic [TW-1:0] START = TW'(LEAD - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (!hold) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (load) begin
            armed <= 1'b1;
            cnt   <= START;
        end else if (armed && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = armed && (cnt == '0);
endmodule

// File: rtl/ra_exit_seq.sv
module ra_exit_seq
    import ra_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic flush,
    output logic restore,
    output logic redirect,
    output logic last
);
    exit_step_e step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            step <= STEP_FLUSH;
        else if (!en)
            step <= STEP_FLUSH;
        else begin
            unique case (step)
                STEP_FLUSH:    step <= STEP_RESTORE;
                STEP_RESTORE:  step <= STEP_REDIRECT;
                STEP_REDIRECT: step <= STEP_FLUSH;
                default:       step <= STEP_FLUSH;
            endcase
        end
    end

    always_comb begin
        flush    = 1'b0;
        restore  = 1'b0;
        redirect = 1'b0;
        if (en) begin
            unique case (step)
                STEP_FLUSH:    flush    = 1'b1;
                STEP_RESTORE:  restore  = 1'b1;
                STEP_REDIRECT: redirect = 1'b1;
                default:       flush    = 1'b0;
            endcase
        end
        last = redirect;
    end
endmodule

// File: rtl/ra_mode_ctrl.sv
module ra_mode_ctrl
    import ra_pkg::*;
#(
    parameter int PCW  = 32,
    parameter int CW   = 4,
    parameter int LEAD = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           l2_miss_valid,
    input  logic [PCW-1:0] l2_miss_pc,
    input  logic           fill_warn,
    input  logic           fill_done,
    input  logic [CW-1:0]  miss_thresh,
    input  logic           exc_req,
    input  logic           irq_req,
    output logic           ckpt_save,
    output logic           runahead_active,
    output logic           flush,
    output logic           restore,
    output logic           redirect,
    output logic [PCW-1:0] redirect_pc,
    output logic           exc_take,
    output logic           irq_take
);
    ra_state_e state, state_nx;

    logic [CW-1:0]  miss_cnt;
    logic [PCW-1:0] trig_pc;
    logic           irq_held;
    logic           below;
    logic           in_ra, in_exit, in_norm;
    logic           linger_armed, linger_done, linger_load;
    logic           seq_last;
    logic           tally_clr, tally_inc;

    assign in_norm = (state == RA_NORMAL);
    assign in_ra   = (state == RA_RUNAHEAD);
    assign in_exit = (state == RA_EXITING);
    assign below   = (miss_cnt < miss_thresh);

    assign tally_clr   = in_norm && l2_miss_valid;
    assign tally_inc   = in_ra && l2_miss_valid;
    assign linger_load = in_ra && fill_done && !below;

    ra_miss_tally #(.CW(CW)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tally_clr),
        .inc   (tally_inc),
        .count (miss_cnt)
    );

    ra_linger_timer #(.LEAD(LEAD)) u_linger (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (in_ra),
        .load    (linger_load),
        .armed   (linger_armed),
        .expired (linger_done)
    );

    ra_exit_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (in_exit),
        .flush    (flush),
        .restore  (restore),
        .redirect (redirect),
        .last     (seq_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RA_NORMAL;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            RA_NORMAL:
                if (l2_miss_valid) state_nx = RA_RUNAHEAD;
            RA_RUNAHEAD:
                if (((fill_warn || fill_done) && below) ||
                    (linger_armed && linger_done))
                    state_nx = RA_EXITING;
            RA_EXITING:
                if (seq_last) state_nx = RA_NORMAL;
            default:
                state_nx = RA_NORMAL;
        endcase
    end

    // checkpoint PC and held interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_pc  <= '0;
            irq_held <= 1'b0;
        end else begin
            if (in_norm && l2_miss_valid)
                trig_pc <= l2_miss_pc;
            if (in_norm)
                irq_held <= 1'b0;
            else if (irq_req)
                irq_held <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ckpt_save       = in_norm && l2_miss_valid;
        runahead_active = !in_norm;
        redirect_pc     = trig_pc;
        exc_take        = in_norm && exc_req;
        irq_take        = in_norm && (irq_req || irq_held);
    end
endmodule

// File: rtl/ra_mode_ctrl_chk.sv
module ra_mode_ctrl_chk #(
    parameter int PCW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ckpt_save,
    input logic           runahead_active,
    input logic           flush,
    input logic           restore,
    input logic           redirect,
    input logic [PCW-1:0] redirect_pc,
    input logic           exc_take,
    input logic           irq_take
);
    // R1
    ckpt_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_save |=> runahead_active);

    // R2
    no_reckpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        runahead_active |-> !ckpt_save);

    // R2
    pc_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (runahead_active && $past(runahead_active)) |-> $stable(redirect_pc));

    // R3
    flush_then_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> restore);

    // R3
    restore_then_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> redirect);

    // R3
    redirect_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !runahead_active);

    // R3
    exit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush, restore, redirect}));

    // R7
    exc_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        runahead_active |-> !exc_take);

    // R8
    irq_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        runahead_active |-> !irq_take);
endmodule

bind ra_mode_ctrl ra_mode_ctrl_chk #(.PCW(PCW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ckpt_save       (ckpt_save),
    .runahead_active (runahead_active),
    .flush           (flush),
    .restore         (restore),
    .redirect        (redirect),
    .redirect_pc     (redirect_pc),
    .exc_take        (exc_take),
    .irq_take        (irq_take)
);

// File: tb/ra_mode_ctrl_test.sv
`timescale 1ns/1ps
module ra_mode_ctrl_test;
    localparam int PCW  = 32;
    localparam int CW   = 4;
    localparam int LEAD = 20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           l2_miss_valid = 1'b0;
    logic [PCW-1:0] l2_miss_pc = '0;
    logic           fill_warn = 1'b0;
    logic           fill_done = 1'b0;
    logic [CW-1:0]  miss_thresh = '0;
    logic           exc_req = 1'b0;
    logic           irq_req = 1'b0;
    logic           ckpt_save, runahead_active, flush, restore, redirect;
    logic [PCW-1:0] redirect_pc;
    logic           exc_take, irq_take;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ra_mode_ctrl #(.PCW(PCW), .CW(CW), .LEAD(LEAD)) uut (
        .clk(clk), .rst_n(rst_n), .l2_miss_valid(l2_miss_valid),
        .l2_miss_pc(l2_miss_pc), .fill_warn(fill_warn), .fill_done(fill_done),
        .miss_thresh(miss_thresh), .exc_req(exc_req), .irq_req(irq_req),
        .ckpt_save(ckpt_save), .runahead_active(runahead_active),
        .flush(flush), .restore(restore), .redirect(redirect),
        .redirect_pc(redirect_pc), .exc_take(exc_take), .irq_take(irq_take)
    );

    task automatic check(input string req, input string what,
                         input logic [PCW-1:0] act, input logic [PCW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic next();
        @(negedge clk);
        #1;
    endtask

    task automatic enter(input logic [PCW-1:0] pc);
        @(negedge clk);
        l2_miss_valid = 1'b1;
        l2_miss_pc    = pc;
        #1 check("R1", "ckpt_save on entry", ckpt_save, 1);
        @(negedge clk);
        l2_miss_valid = 1'b0;
        l2_miss_pc    = '0;
        #1 check("R1", "runahead_active after entry", runahead_active, 1);
    endtask

    task automatic more_misses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            l2_miss_valid = 1'b1;
            l2_miss_pc    = 32'hDEAD_0000 + i;
            #1;
            if (i == 0) check("R2", "no ckpt_save while running ahead", ckpt_save, 0);
        end
        @(negedge clk);
        l2_miss_valid = 1'b0;
        #1;
    endtask

    task automatic pulse_warn();
        @(negedge clk);
        fill_warn = 1'b1;
        @(negedge clk);
        fill_warn = 1'b0;
        #1;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        fill_done = 1'b1;
        @(negedge clk);
        fill_done = 1'b0;
        #1;
    endtask

    // called in the cycle where flush should be high
    task automatic expect_exit(input logic [PCW-1:0] pc, input logic irq_exp);
        check("R3", "flush", {flush, restore, redirect}, 3'b100);
        next();
        check("R3", "restore", {flush, restore, redirect}, 3'b010);
        next();
        check("R3", "redirect", {flush, restore, redirect}, 3'b001);
        check("R3", "redirect_pc", redirect_pc, pc);
        next();
        check("R3", "normal after redirect", runahead_active, 0);
        check("R8", "irq_take after redirect", irq_take, irq_exp);
        next();
        check("R8", "irq_take one cycle only", irq_take, 0);
    endtask

    // called right after the edge that sampled fill_done
    task automatic expect_linger();
        check("R5", "no flush at return", flush, 0);
        for (int k = 1; k < LEAD; k++) begin
            next();
            if (flush !== 1'b0 || runahead_active !== 1'b1)
                check("R5", "linger window", {flush, runahead_active}, 2'b01);
        end
        next();
        check("R5", "flush after LEAD cycles", flush, 1);
    endtask

    task automatic test_reset();
        check("R11", "outputs in reset",
              {ckpt_save, runahead_active, flush, restore, redirect, exc_take, irq_take}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R11", "outputs after reset",
                 {ckpt_save, runahead_active, flush, restore, redirect, exc_take, irq_take}, 0);
    endtask

    task automatic test_normal_passthrough();
        @(negedge clk);
        exc_req = 1'b1;
        irq_req = 1'b1;
        #1;
        check("R7", "exc_take in normal", exc_take, 1);
        check("R8", "irq_take in normal", irq_take, 1);
        @(negedge clk);
        exc_req = 1'b0;
        irq_req = 1'b0;
        fill_warn = 1'b1;
        fill_done = 1'b1;
        @(negedge clk);
        fill_warn = 1'b0;
        fill_done = 1'b0;
        #1;
        check("R10", "fill inputs ignored in normal", {runahead_active, flush}, 0);
        next();
        check("R10", "still normal", {runahead_active, flush}, 0);
    endtask

    task automatic test_early_exit();
        miss_thresh = 4'd5;
        enter(32'h0000_1000);
        more_misses(2);
        pulse_warn();
        check("R4", "flush after early warning", flush, 1);
        expect_exit(32'h0000_1000, 1'b0);
    endtask

    task automatic test_late_exit();
        miss_thresh = 4'd5;
        enter(32'h0000_2040);
        more_misses(6);
        @(negedge clk);
        exc_req = 1'b1;
        irq_req = 1'b1;
        #1 check("R7", "exception dropped in runahead", exc_take, 0);
        @(negedge clk);
        exc_req = 1'b0;
        irq_req = 1'b0;
        pulse_warn();
        check("R5", "warning ignored with many misses", {flush, runahead_active}, 2'b01);
        pulse_done();
        expect_linger();
        expect_exit(32'h0000_2040, 1'b1);
    endtask

    task automatic test_baseline();
        miss_thresh = 4'd3;
        enter(32'h0000_3000);
        more_misses(1);
        pulse_done();
        check("R6", "flush after return with few misses", flush, 1);
        expect_exit(32'h0000_3000, 1'b0);
    endtask

    task automatic test_saturate_and_clear();
        miss_thresh = 4'd15;
        enter(32'h0000_4000);
        more_misses(20);
        pulse_done();
        check("R2", "saturated count keeps late exit", flush, 0);
        expect_linger();
        expect_exit(32'h0000_4000, 1'b0);
        enter(32'h0000_5000);
        pulse_done();
        check("R9", "count cleared on entry", flush, 1);
        expect_exit(32'h0000_5000, 1'b0);
    endtask

    initial begin
        #5;
        test_reset();
        test_normal_passthrough();
        test_early_exit();
        test_late_exit();
        test_baseline();
        test_saturate_and_clear();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule